// File: doc/BRIEF.md
# Key Buffer and Quadrature Dial Counter

This peripheral sits on an APB bus and gathers the inputs of a small hand-held control panel. The panel has five push keys and a rotary dial. Each key pulls its line to ground when pressed. The dial puts out two phase lines in Gray code. The block registers the key lines once against the clock and inverts them. Software then reads the keys as an active-high bitmap at offset 00h.

Both dial phases pass through a synchronizer chain. Each legal single-phase change then counts as one rotation step, up or down. The steps collect in an 8-bit two's-complement counter at offset 04h, which reads back sign-extended to the full bus width.

Software does not clear the counter by loading it. It writes back the amount it has already used, and the block subtracts that amount. A step that lands in the same cycle as the write is still counted, so no rotation is lost between a read and the write that follows it.

Top module: `panel_input_apb`

## Requirements
- R1: A read at offset 00h returns the pressed keys as ones: shutter at bit 6, autofocus at bit 5, shift at bit 4, return at bit 2 and enter at bit 1. Bits 31:7, 3 and 0 read as zero. Pin index on `keyPinN` is 0=enter, 1=return, 2=shift, 3=autofocus, 4=shutter, and a low pin means pressed.
- R2: A key pin change appears in the key bitmap after exactly one rising clock edge.
- R3: In the phase order {A,B} = 00→01→11→10→00, each step adds one to the counter, and each step in the reverse order subtracts one. The new count is readable after the third rising edge following the pin change.
- R4: A sampled change in which both phases toggle together leaves the counter unchanged.
- R5: A read at offset 04h returns the 8-bit count sign-extended to 32 bits.
- R6: A write at offset 04h subtracts bits 7:0 of the write data from the counter. Bits 31:8 of the write data are ignored.
- R7: When a rotation step and a counter write land in the same cycle, the result is count − written value ± 1.
- R8: The counter wraps modulo 256 in both directions and does not saturate.
- R9: After reset the key bitmap and the counter read zero, and the initial phase levels produce no step.
- R10: Writes at any offset other than 04h change no state, and reads at offsets other than 00h and 04h return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 4 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero when not selected |
| keyPinN | input | 5 | Raw active-low key lines |
| phaseA | input | 1 | Dial phase A, asynchronous |
| phaseB | input | 1 | Dial phase B, asynchronous |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a two-stage phase synchronizer. With these settings, a single subtracting write can move the count to +127. One more step then crosses the ±128 boundary, so the wrap and the sign extension can be reached without hundreds of dial steps. The fixed three-edge phase latency also lets the bench place a rotation step in the exact access cycle of a counter write.

// File: rtl/panel_input_pkg.sv
package panel_input_pkg;

  localparam int KEY_OFFSET  = 'h0;
  localparam int DIAL_OFFSET = 'h4;
  localparam int NUM_KEYS    = 5;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic countUp;
    logic countDown;
    logic subtract;
  } dialStrobe_t;

  // bit position of each key in the status word; index order follows the pins
  function automatic int keyBitPos(input int idx);
    case (idx)
      0: keyBitPos = 1;  // enter
      1: keyBitPos = 2;  // return
      2: keyBitPos = 4;  // shift
      3: keyBitPos = 5;  // autofocus
      default: keyBitPos = 6;  // shutter
    endcase
  endfunction

endpackage

// File: rtl/panel_dial_ctrl.sv
module panel_dial_ctrl
  import panel_input_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output dialStrobe_t       strobe
);

  localparam int FILL   = SYNC_STAGES + 1;
  localparam int FILL_W = $clog2(FILL + 1);

  logic [1:0] syncChain [SYNC_STAGES];
  logic [1:0] phaseNow;
  logic [1:0] phasePrev;
  logic [FILL_W-1:0] fillCnt;
  logic primed;
  logic [1:0] changed;
  logic legalStep;
  logic forward;

  // {A,B} synchronizer stages
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 2'b00;
        else       syncChain[g] <= {phaseA, phaseB};
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 2'b00;
        else       syncChain[g] <= syncChain[g-1];
      end
    end
  end

  assign phaseNow = syncChain[SYNC_STAGES-1];

  // the decoder waits until the chain and the previous state hold real samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phasePrev <= 2'b00;
      fillCnt   <= '0;
    end else begin
      phasePrev <= phaseNow;
      if (fillCnt != FILL_W'(FILL)) fillCnt <= fillCnt + 1'b1;
    end
  end

  assign primed    = (fillCnt == FILL_W'(FILL));
  assign changed   = phaseNow ^ phasePrev;
  assign legalStep = (changed == 2'b01) || (changed == 2'b10);
  // forward order 00,01,11,10: old A differs from new B
  assign forward   = phasePrev[1] ^ phaseNow[0];

  always_comb begin
    strobe.countUp   = primed && legalStep && forward;
    strobe.countDown = primed && legalStep && !forward;
    strobe.subtract  = psel && penable && pwrite && (paddr == ADDR_W'(DIAL_OFFSET));
  end

endmodule

// File: rtl/panel_input_dp.sv
module panel_input_dp
  import panel_input_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyPinN,
  input  dialStrobe_t         strobe,
  input  logic [CNT_W-1:0]    subValue,
  input  logic                psel,
  input  logic [ADDR_W-1:0]   paddr,
  output logic [DATA_W-1:0]   prdata,
  output logic [CNT_W-1:0]    dialCount
);

  localparam int EXT_W = DATA_W - CNT_W;

  logic [NUM_KEYS-1:0] keyStatus;
  logic [DATA_W-1:0]   keyWord;
  logic [CNT_W-1:0]    countQ;
  logic [CNT_W-1:0]    delta;
  logic [CNT_W-1:0]    takeAway;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyStatus <= '0;
    else       keyStatus <= ~keyPinN;
  end

  always_comb begin
    keyWord = '0;
    for (int i = 0; i < NUM_KEYS; i++) keyWord[keyBitPos(i)] = keyStatus[i];
  end

  always_comb begin
    if (strobe.countUp)        delta = CNT_W'(1);
    else if (strobe.countDown) delta = '1;
    else                       delta = '0;
    takeAway = strobe.subtract ? subValue : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countQ - takeAway + delta;
  end

  assign dialCount = countQ;

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (paddr == ADDR_W'(KEY_OFFSET))       prdata = keyWord;
      else if (paddr == ADDR_W'(DIAL_OFFSET)) prdata = {{EXT_W{countQ[CNT_W-1]}}, countQ};
    end
  end

endmodule

// File: rtl/panel_input_apb.sv
module panel_input_apb
  import panel_input_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W-1:0]   prdata,
  input  logic [NUM_KEYS-1:0] keyPinN,
  input  logic                phaseA,
  input  logic                phaseB
);

  dialStrobe_t      strobe;
  logic [CNT_W-1:0] dialCount;

  panel_dial_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .strobe(strobe)
  );

  panel_input_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .keyPinN(keyPinN), .strobe(strobe),
    .subValue(pwdata[CNT_W-1:0]), .psel(psel), .paddr(paddr),
    .prdata(prdata), .dialCount(dialCount)
  );

endmodule

// File: rtl/panel_input_checker.sv
module panel_input_checker
  import panel_input_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                psel,
  input logic [ADDR_W-1:0]   paddr,
  input logic [DATA_W-1:0]   pwdata,
  input logic [DATA_W-1:0]   prdata,
  input logic [NUM_KEYS-1:0] keyPinN,
  input dialStrobe_t         strobe,
  input logic [CNT_W-1:0]    dialCount
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_key_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (psel && paddr == ADDR_W'(KEY_OFFSET)) |->
      (prdata[DATA_W-1:7] == '0 && prdata[3] == 1'b0 && prdata[0] == 1'b0));

  assert_key_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && psel && paddr == ADDR_W'(KEY_OFFSET)) |->
      (prdata[6] == !$past(keyPinN[4]) && prdata[1] == !$past(keyPinN[0])));

  assert_step_unit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strobe.subtract)) |->
      (dialCount == $past(dialCount) || dialCount == $past(dialCount) + ONE ||
       dialCount == $past(dialCount) - ONE));

  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rstN)
    (psel && paddr == ADDR_W'(DIAL_OFFSET)) |->
      (prdata[DATA_W-1:CNT_W] == {(DATA_W-CNT_W){prdata[CNT_W-1]}}));

  assert_write_sub_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobe.subtract) && !$past(strobe.countUp) && !$past(strobe.countDown)) |->
      (dialCount == CNT_W'($past(dialCount) - $past(pwdata[CNT_W-1:0]))));

endmodule

bind panel_input_apb panel_input_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .paddr(paddr), .pwdata(pwdata),
  .prdata(prdata), .keyPinN(keyPinN), .strobe(strobe), .dialCount(dialCount)
);

// File: tb/panel_input_apb_bench.sv
module panel_input_apb_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [4:0]  keyPinN = 5'b11111;
  logic        phaseA = 1'b0;
  logic        phaseB = 1'b1;

  int checks = 0;
  int fails = 0;
  int phIdx = 1;  // index into 00,01,11,10; starts at 01
  bit done = 1'b0;

  always #5 clk = ~clk;

  panel_input_apb u_panel_input_apb (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .keyPinN(keyPinN),
    .phaseA(phaseA), .phaseB(phaseB)
  );

  function automatic logic [1:0] grayAt(input int i);
    case (i)
      0: grayAt = 2'b00;
      1: grayAt = 2'b01;
      2: grayAt = 2'b11;
      default: grayAt = 2'b10;
    endcase
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1; #1 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic drivePhase();
    {phaseA, phaseB} = grayAt(phIdx);
  endtask

  task automatic stepDial(input bit fwd);
    @(negedge clk);
    phIdx = fwd ? (phIdx + 1) % 4 : (phIdx + 3) % 4;
    drivePhase();
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    apbRead(4'h0, d); checkEq("R9 keys after reset", d, 32'h0);
    apbRead(4'h4, d); checkEq("R9 count after reset, phases at 01", d, 32'h0);
  endtask

  task automatic testKeys();
    logic [31:0] d;
    // shutter and return pressed
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = 4'h0; keyPinN = 5'b01101;
    #1 checkEq("R2 key not yet visible", prdata, 32'h0);
    @(posedge clk); #1 checkEq("R2 key after one edge", prdata, 32'h44);
    @(negedge clk); psel = 1'b0;
    @(negedge clk); keyPinN = 5'b10010;  // enter, shift, autofocus
    apbRead(4'h0, d); checkEq("R1 enter shift autofocus", d, 32'h32);
    @(negedge clk); keyPinN = 5'b00000;
    apbRead(4'h0, d); checkEq("R1 all keys", d, 32'h76);
    @(negedge clk); keyPinN = 5'b11111;
    apbRead(4'h0, d); checkEq("R1 released", d, 32'h0);
  endtask

  task automatic testRotation();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) stepDial(1'b1);
    apbRead(4'h4, d); checkEq("R3 four steps forward", d, 32'h4);
    for (int i = 0; i < 6; i++) stepDial(1'b0);
    apbRead(4'h4, d); checkEq("R3 R5 six back, negative", d, 32'hFFFF_FFFE);
  endtask

  task automatic testLatency();
    logic [31:0] d;
    // count -2 now; step forward and watch the third edge
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = 4'h4;
    phIdx = (phIdx + 1) % 4; drivePhase();
    @(posedge clk); @(posedge clk); #1 checkEq("R3 unchanged after two edges", prdata, 32'hFFFF_FFFE);
    @(posedge clk); #1 checkEq("R3 updated after third edge", prdata, 32'hFFFF_FFFF);
    @(negedge clk); psel = 1'b0;
    stepDial(1'b0);
    apbRead(4'h4, d); checkEq("R3 back to -2", d, 32'hFFFF_FFFE);
  endtask

  task automatic testInvalid();
    logic [31:0] d;
    @(negedge clk); phIdx = (phIdx + 2) % 4; drivePhase();
    repeat (4) @(negedge clk);
    apbRead(4'h4, d); checkEq("R4 double toggle ignored", d, 32'hFFFF_FFFE);
    @(negedge clk); phIdx = (phIdx + 2) % 4; drivePhase();
    repeat (4) @(negedge clk);
    apbRead(4'h4, d); checkEq("R4 double toggle back ignored", d, 32'hFFFF_FFFE);
  endtask

  task automatic testSubtract();
    logic [31:0] d;
    apbWrite(4'h4, 32'hABCD_FFFE);
    apbRead(4'h4, d); checkEq("R6 subtract low byte only", d, 32'h0);
    apbWrite(4'h4, 32'h0000_0081);
    apbRead(4'h4, d); checkEq("R6 R8 subtract to +127", d, 32'h7F);
    stepDial(1'b1);
    apbRead(4'h4, d); checkEq("R8 R5 wrap to -128", d, 32'hFFFF_FF80);
    stepDial(1'b0);
    apbRead(4'h4, d); checkEq("R8 wrap back to +127", d, 32'h7F);
    apbWrite(4'h4, 32'h0000_007E);
    apbRead(4'h4, d); checkEq("R6 subtract to 1", d, 32'h1);
  endtask

  task automatic testConcurrent();
    logic [31:0] d;
    @(negedge clk); phIdx = (phIdx + 1) % 4; drivePhase();
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = 4'h4; pwdata = 32'h3;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    apbRead(4'h4, d); checkEq("R7 step during write kept", d, 32'hFFFF_FFFF);
    @(negedge clk); phIdx = (phIdx + 3) % 4; drivePhase();
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = 4'h4; pwdata = 32'hFF;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    apbRead(4'h4, d); checkEq("R7 back step during write kept", d, 32'hFFFF_FFFF);
  endtask

  task automatic testIgnored();
    logic [31:0] d;
    @(negedge clk); keyPinN = 5'b11110;
    apbWrite(4'h0, 32'hFFFF_FFFF);
    apbWrite(4'h8, 32'h0000_0005);
    apbRead(4'h4, d); checkEq("R10 count untouched by other writes", d, 32'hFFFF_FFFF);
    apbRead(4'h0, d); checkEq("R10 keys untouched by write", d, 32'h2);
    apbRead(4'h8, d); checkEq("R10 unmapped read zero", d, 32'h0);
    apbRead(4'hC, d); checkEq("R10 unmapped read zero at 0C", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    drivePhase();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    testReset();
    testKeys();
    testRotation();
    testLatency();
    testInvalid();
    testSubtract();
    testConcurrent();
    testIgnored();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule